// File: doc/BRIEF.md
# Address-Hazard Loop Predicate Generator

This block looks at two byte addresses used in one iteration of a vectorised loop. The first is the base that a contiguous load reads. The second is the base that a contiguous store writes. From these it builds a per-byte lane predicate. The predicate marks the elements that one vector iteration can process before the written range can overlap data that is still to be read.

The lane limit is the signed distance from the read base to the write base, divided by the element size. The division rounds toward negative infinity. When the limit is zero or negative, the two ranges cannot collide in a harmful order, so every lane is enabled. When the limit is positive, only elements below the limit are enabled.

The predicate has one bit per byte of the vector. Only the lowest bit of each element's byte group carries that element's state. Four condition flags summarise the result. The vector width is a parameter. Results appear one clock after a valid request.

Top module: `hazard_pred_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `pred_out` and all four flags are 0 after that edge.
- R2: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` high. A cycle with `in_valid` low leaves `pred_out` and the flags unchanged.
- R3: `size_code` 0, 1, 2 and 3 select elements of 1, 2, 4 and 8 bytes. A `pred_out` bit can be 1 only at a byte index that is a multiple of the element byte count.
- R4: The lane limit is (`wr_base` − `rd_base`), taken as a 65-bit signed difference of the unsigned addresses, shifted arithmetically right by `size_code`. This is floor division by the element byte count.
- R5: If the lane limit is zero or negative, every element is active. This case covers equal bases, a write base below the read base, and a positive distance smaller than one element.
- R6: If the lane limit is positive, element e (at predicate bit e × element bytes) is active exactly when e is less than the limit. All other bits of the predicate are 0.
- R7: `flag_n` is 1 when element 0 is active.
- R8: `flag_z` is 1 when no element is active.
- R9: `flag_c` is the inverse of the activity of the highest element, whose bit is at index VL/8 − element bytes.
- R10: `flag_v` is always 0.
- R11: A lane limit equal to or greater than the element count enables every element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; inputs are evaluated in this cycle |
| rd_base | input | ADDR_W | Read base address (first operand) |
| wr_base | input | ADDR_W | Write base address (second operand) |
| size_code | input | 2 | Element size code |
| out_valid | output | 1 | Result valid, one cycle after request |
| pred_out | output | VL_BITS/8 | Per-byte lane predicate |
| flag_n | output | 1 | First element active |
| flag_z | output | 1 | No element active |
| flag_c | output | 1 | Last element not active |
| flag_v | output | 1 | Always zero |

## Verification
A wrong sign or width in the distance arithmetic appears as a fully enabled or fully disabled predicate for nearby bases. It shows up on the first result after the request that exposes it. A wrong shift or grouping for one size code sets predicate bits off the element grid, or moves the cut-off lane, in the same result cycle. Wrong flag logic disagrees with the predicate bits in the same cycle, and the checker compares the two whenever `out_valid` is high. A wrong capture enable shows as a predicate that moves while `in_valid` is low, one cycle after the idle input changes.

// File: rtl/hpg_pkg.sv
package hpg_pkg;

   typedef enum logic [1:0] {
      ESZ_BYTE  = 2'd0,
      ESZ_HALF  = 2'd1,
      ESZ_WORD  = 2'd2,
      ESZ_DWORD = 2'd3
   } esize_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } cond_flags_t;

endpackage

// File: rtl/hpg_dist.sv
// Signed distance between the bases, scaled to an element count (R4).
module hpg_dist
   import hpg_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int CNT_W  = 6
) (
   input  logic [ADDR_W-1:0] base_rd,
   input  logic [ADDR_W-1:0] base_wr,
   input  esize_e            size,
   output logic              lim_all,
   output logic [CNT_W-1:0]  lim_cnt
);
   localparam int DW = ADDR_W + 1;

   logic signed [DW-1:0] diff;
   logic signed [DW-1:0] lim;
   logic                 non_pos;
   logic                 too_big;

   always_comb begin
      diff    = $signed({1'b0, base_wr}) - $signed({1'b0, base_rd});
      lim     = diff >>> size;
      // R5: zero or negative limit opens every lane
      non_pos = lim[DW-1] | (lim == '0);
      // R11: positive limit beyond the counter range opens every lane
      too_big = ~lim[DW-1] & (|lim[DW-2:CNT_W]);
      lim_all = non_pos | too_big;
      lim_cnt = lim[CNT_W-1:0];
   end
endmodule

// File: rtl/hpg_lanes.sv
// Per-byte predicate construction for all element sizes (R3, R6).
module hpg_lanes
   import hpg_pkg::*;
#(
   parameter int PRED_W = 32,
   parameter int CNT_W  = 6
) (
   input  esize_e            size,
   input  logic              lim_all,
   input  logic [CNT_W-1:0]  lim_cnt,
   output logic [PRED_W-1:0] pred
);
   localparam int NSIZE = 4;

   for (genvar b = 0; b < PRED_W; b++) begin : g_byte
      logic [NSIZE-1:0] cand;
      for (genvar s = 0; s < NSIZE; s++) begin : g_size
         localparam int unsigned EBYTES = 1 << s;
         localparam int unsigned EIDX   = b >> s;
         if ((b % EBYTES) == 0) begin : g_lead
            assign cand[s] = lim_all | (CNT_W'(EIDX) < lim_cnt);
         end else begin : g_fill
            assign cand[s] = 1'b0;
         end
      end
      assign pred[b] = cand[size];
   end
endmodule

// File: rtl/hpg_flags.sv
// Condition flags derived from the predicate (R7..R10).
module hpg_flags
   import hpg_pkg::*;
#(
   parameter int PRED_W = 32
) (
   input  logic [PRED_W-1:0] pred,
   input  esize_e            size,
   output cond_flags_t       flags
);
   localparam int IDX_W = $clog2(PRED_W);

   logic [IDX_W-1:0] last_idx;

   always_comb begin
      unique case (size)
         ESZ_BYTE:  last_idx = IDX_W'(PRED_W - 1);
         ESZ_HALF:  last_idx = IDX_W'(PRED_W - 2);
         ESZ_WORD:  last_idx = IDX_W'(PRED_W - 4);
         ESZ_DWORD: last_idx = IDX_W'(PRED_W - 8);
         default:   last_idx = IDX_W'(PRED_W - 1);
      endcase
      flags.n = pred[0];
      flags.z = ~|pred;
      flags.c = ~pred[last_idx];
      flags.v = 1'b0;
   end
endmodule

// File: rtl/hazard_pred_gen.sv
module hazard_pred_gen
   import hpg_pkg::*;
#(
   parameter int VL_BITS = 256,
   parameter int ADDR_W  = 64
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   in_valid,
   input  logic [ADDR_W-1:0]      rd_base,
   input  logic [ADDR_W-1:0]      wr_base,
   input  logic [1:0]             size_code,
   output logic                   out_valid,
   output logic [VL_BITS/8-1:0]   pred_out,
   output logic                   flag_n,
   output logic                   flag_z,
   output logic                   flag_c,
   output logic                   flag_v
);
   localparam int PRED_W = VL_BITS / 8;
   localparam int CNT_W  = $clog2(PRED_W) + 1;

   if ((VL_BITS % 128) != 0 || VL_BITS < 128 || VL_BITS > 2048) begin : g_bad_vl
      $error("hazard_pred_gen: VL_BITS must be a multiple of 128 in 128..2048");
   end
   if (ADDR_W < CNT_W + 2) begin : g_bad_aw
      $error("hazard_pred_gen: ADDR_W too small for the lane counter");
   end

   esize_e            size_e;
   logic              lim_all;
   logic [CNT_W-1:0]  lim_cnt;
   logic [PRED_W-1:0] pred_c;
   cond_flags_t       flags_c;
   logic [PRED_W-1:0] pred_q;
   cond_flags_t       flags_q;
   logic              vld_q;

   assign size_e = esize_e'(size_code);

   hpg_dist #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dist (
      .base_rd (rd_base),
      .base_wr (wr_base),
      .size    (size_e),
      .lim_all (lim_all),
      .lim_cnt (lim_cnt)
   );

   hpg_lanes #(.PRED_W(PRED_W), .CNT_W(CNT_W)) u_lanes (
      .size    (size_e),
      .lim_all (lim_all),
      .lim_cnt (lim_cnt),
      .pred    (pred_c)
   );

   hpg_flags #(.PRED_W(PRED_W)) u_flags (
      .pred  (pred_c),
      .size  (size_e),
      .flags (flags_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q   <= 1'b0;
         pred_q  <= '0;
         flags_q <= '0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) begin
            pred_q  <= pred_c;
            flags_q <= flags_c;
         end
      end
   end

   assign out_valid = vld_q;
   assign pred_out  = pred_q;
   assign flag_n    = flags_q.n;
   assign flag_z    = flags_q.z;
   assign flag_c    = flags_q.c;
   assign flag_v    = flags_q.v;
endmodule

// File: rtl/hpg_checker.sv
module hpg_checker #(
   parameter int PRED_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [1:0]        size_code,
   input logic              out_valid,
   input logic [PRED_W-1:0] pred_out,
   input logic              flag_n,
   input logic              flag_z,
   input logic              flag_c,
   input logic              flag_v
);
   localparam int IDX_W = $clog2(PRED_W);

   logic [1:0]        size_q;
   logic [PRED_W-1:0] grid;
   logic [IDX_W-1:0]  last_q;

   always_ff @(posedge clk) begin
      if (rst)           size_q <= 2'd0;
      else if (in_valid) size_q <= size_code;
   end

   for (genvar b = 0; b < PRED_W; b++) begin : g_grid
      assign grid[b] = ((b & ((1 << size_q) - 1)) == 0);
   end
   assign last_q = IDX_W'(PRED_W - (1 << size_q));

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (!out_valid && pred_out == '0 && !flag_n && !flag_z && !flag_c && !flag_v)); // R1
   AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R2
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(pred_out) && $stable(flag_c))); // R2
   AST_GRID_ONLY: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ((pred_out & ~grid) == '0)); // R3
   AST_FIRST_N: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (flag_n == pred_out[0])); // R7
   AST_NONE_Z: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (flag_z == (pred_out == '0))); // R8
   AST_LAST_C: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (flag_c == !pred_out[last_q])); // R9
   AST_V_ZERO: assert property (@(posedge clk) disable iff (rst)
      !flag_v); // R10
endmodule

bind hazard_pred_gen hpg_checker #(.PRED_W(PRED_W)) u_hpg_checker (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .size_code (size_code),
   .out_valid (out_valid),
   .pred_out  (pred_out),
   .flag_n    (flag_n),
   .flag_z    (flag_z),
   .flag_c    (flag_c),
   .flag_v    (flag_v)
);

// File: tb/hazard_pred_gen_bench.sv
module hazard_pred_gen_bench;
   localparam int VL = 256;
   localparam int PW = VL / 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [63:0]   rd_base = '0;
   logic [63:0]   wr_base = '0;
   logic [1:0]    size_code = '0;
   logic          out_valid;
   logic [PW-1:0] pred_out;
   logic          flag_n, flag_z, flag_c, flag_v;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   hazard_pred_gen #(.VL_BITS(VL), .ADDR_W(64)) u_hazard_pred_gen (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .rd_base(rd_base), .wr_base(wr_base), .size_code(size_code),
      .out_valid(out_valid), .pred_out(pred_out),
      .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [PW-1:0] model(input logic [63:0] a, input logic [63:0] b,
                                           input logic [1:0] sz);
      logic signed [65:0] d;
      logic signed [65:0] l;
      logic [PW-1:0]      r;
      int                 eb;
      d  = $signed({2'b00, b}) - $signed({2'b00, a});
      l  = d >>> sz;
      eb = 1 << sz;
      r  = '0;
      for (int e = 0; e < PW / eb; e++)
         if (l <= 66'sd0 || 66'(e) < l) r[e*eb] = 1'b1;
      return r;
   endfunction

   task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [1:0] sz);
      @(negedge clk);
      rd_base = a; wr_base = b; size_code = sz; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic run(input logic [63:0] a, input logic [63:0] b, input logic [1:0] sz,
                      input string req);
      logic [PW-1:0] e;
      int            eb;
      apply(a, b, sz);
      e  = model(a, b, sz);
      eb = 1 << sz;
      chk({req, " pred"}, 64'(pred_out), 64'(e));
      chk("R2 out_valid", 64'(out_valid), 64'd1);
      chk("R7 flag_n", 64'(flag_n), 64'(e[0]));
      chk("R8 flag_z", 64'(flag_z), 64'(e == '0));
      chk("R9 flag_c", 64'(flag_c), 64'(!e[PW-eb]));
      chk("R10 flag_v", 64'(flag_v), 64'd0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 out_valid", 64'(out_valid), 64'd0);
      chk("R1 pred", 64'(pred_out), 64'd0);
      chk("R1 flags", 64'({flag_n, flag_z, flag_c, flag_v}), 64'd0);
   endtask

   task automatic t_equal();
      run(64'h1000, 64'h1000, 2'd0, "R5 equal");
      chk("R5 equal all", 64'(pred_out), 64'hFFFF_FFFF);
   endtask

   task automatic t_negative();
      run(64'h2000, 64'h1F00, 2'd2, "R5 negative");
      chk("R5 negative all", 64'(pred_out), 64'h1111_1111);
      run(64'hFFFF_FFFF_FFFF_FFF0, 64'h10, 2'd0, "R5 wrap");
   endtask

   task automatic t_small_pos();
      run(64'h100, 64'h103, 2'd2, "R4 sub-element");
      chk("R4 floor to zero", 64'(pred_out), 64'h1111_1111);
   endtask

   task automatic t_one_elem();
      run(64'h400, 64'h408, 2'd3, "R6 one element");
      chk("R6 only lane 0", 64'(pred_out), 64'h1);
      chk("R9 last inactive", 64'(flag_c), 64'd1);
   endtask

   task automatic t_mid();
      run(64'h800, 64'h80A, 2'd1, "R6 five halves");
      chk("R4 limit five", 64'(pred_out), 64'h155);
   endtask

   task automatic t_big();
      run(64'h0, 64'd1000, 2'd0, "R11 far");
      chk("R11 all bytes", 64'(pred_out), 64'hFFFF_FFFF);
      run(64'h0, 64'd32, 2'd3, "R11 exact count");
      chk("R11 last active", 64'(flag_c), 64'd0);
      run(64'h0, 64'd24, 2'd3, "R6 count minus one");
      chk("R6 cut at three", 64'(pred_out), 64'h0001_0101);
   endtask

   task automatic t_sizes();
      for (int s = 0; s < 4; s++)
         run(64'h5000, 64'h500C, 2'(s), "R3 size sweep");
   endtask

   task automatic t_hold();
      logic [PW-1:0] snap;
      run(64'h0, 64'd6, 2'd1, "R6 before hold");
      snap = pred_out;
      @(negedge clk);
      rd_base = 64'h0; wr_base = 64'h0; size_code = 2'd0;
      @(negedge clk);
      @(negedge clk);
      chk("R2 hold pred", 64'(pred_out), 64'(snap));
      chk("R2 idle valid", 64'(out_valid), 64'd0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk);
      rst = 1'b0;
      t_equal();
      t_negative();
      t_small_pos();
      t_one_elem();
      t_mid();
      t_big();
      t_sizes();
      t_hold();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule